// File: doc/BRIEF.md
# Combined Access Memory Scheduler

This block lets a group of thread accelerators, running in lockstep, share one DMA read channel. Each accelerator issues private reads as offsets into its own region. The scheduler adds the accelerator's base address to the offset and sends the reads over the channel one at a time, choosing among the requesters in round-robin order. Accelerators that have nothing to read in a round take no slot.

When every member of the group has reached the shared read point, the scheduler issues one read at the common address. The scheduler waits until no private request is waiting, no private response is still in flight and the return buffer is empty. The data that comes back is broadcast on one bus, with a separate valid bit for each member, and each bit clears when that member accepts.

A response tag names the destination. Its top bit is set for the shared read; for a private read it is clear and the low bits carry the accelerator index. An accelerator holds `arrive` high from the point where it has finished its private reads until it has accepted the broadcast.

Top module: `cams_sched`

## Requirements
- R1: After reset `dma_req`, `u_ready` and `rd_valid` are all zero and `dma_rready` is one.
- R2: A private read from accelerator i drives `dma_addr` = base_i + offset_i (modulo 2^AW) and `dma_tag` = {1'b0, i}.
- R3: Private requests are granted one at a time in round-robin order. The search starts at the index after the last granted one, and non-requesting accelerators are passed over.
- R4: No `u_ready` is given while `dma_gnt` is low, and the round-robin position does not move.
- R5: A private response with tag {1'b0, i} is presented on `rd_data` with `rd_valid` having only bit i set, one cycle after the response is accepted.
- R6: The shared read (`dma_tag` top bit set, `dma_addr` = `comb_addr`) is requested only when all four conditions hold: every bit set in `member` has `arrive` high, no private read is outstanding, no private request is pending, and the return buffer is empty.
- R7: While both a private request and the shared read are eligible, the private request is issued first.
- R8: Shared data is broadcast with `rd_valid` equal to `member`. `rd_data` is held, each bit clears only as its accelerator accepts, and `dma_rready` stays low until all bits have cleared.
- R9: From the shared read being issued until one cycle after the broadcast is fully accepted, no private read is requested.
- R10: At most MAX_OUT private reads are outstanding; a further request is held with `dma_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| member | input | N | Accelerators that take part in the shared read |
| base_addr | input | N*AW | Base address of each accelerator, packed |
| u_req | input | N | Private read request per accelerator |
| u_off | input | N*AW | Private read offset per accelerator, packed |
| u_ready | output | N | Private request accepted (one-hot) |
| arrive | input | N | Accelerator has reached the shared read point |
| comb_addr | input | AW | Address of the shared read |
| dma_req | output | 1 | Channel read request |
| dma_addr | output | AW | Channel read address |
| dma_tag | output | IW+1 | Request tag: {shared, index} |
| dma_gnt | input | 1 | Channel accepts the request |
| dma_rvalid | input | 1 | Channel response valid |
| dma_rtag | input | IW+1 | Tag of the response |
| dma_rdata | input | DW | Response data |
| dma_rready | output | 1 | Scheduler can take a response |
| rd_valid | output | N | Data valid per accelerator |
| rd_data | output | DW | Data bus shared by all accelerators |
| rd_ready | input | N | Accelerator accepts the data |

## Verification
Request-side outputs (`dma_req`, `dma_addr`, `dma_tag`, `u_ready`) depend combinationally on the inputs in the same cycle. The bench sets the inputs just after a falling edge and samples these outputs a short time later, before the next rising edge.

Returned data shows on `rd_valid`/`rd_data` one edge after the response is accepted, and each valid bit clears on the edge after its ready. The bench therefore checks delivery one and two falling edges after driving a response.

The round boundary takes two more cycles: the state moves back one edge after the buffer empties. The bench checks that `dma_req` stays low on the first falling edge after the buffer empties and that private requests resume on the second.

// File: rtl/cams_pkg.sv
package cams_pkg;
  typedef enum logic [1:0] {
    PH_UNC   = 2'd0,
    PH_WAIT  = 2'd1,
    PH_BCAST = 2'd2
  } phase_t;
endpackage

// File: rtl/cams_rr_pick.sv
module cams_rr_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [IW-1:0] last_q;

  function automatic logic [IW-1:0] pick_next(input logic [N-1:0] r,
                                              input logic [IW-1:0] last);
    logic [IW-1:0] p;
    logic found;
    p = last;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last) + k) % N;
      if (!found && r[j]) begin
        p = j[IW-1:0];
        found = 1'b1;
      end
    end
    return p;
  endfunction

  assign any = |req;
  assign idx = pick_next(req, last_q);
  assign gnt = any ? ({{(N-1){1'b0}}, 1'b1} << idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IW'(N - 1);
    else if (advance) last_q <= idx;
  end

  p_grant_is_requester_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((gnt & req) == gnt) && $onehot(gnt));
endmodule

// File: rtl/cams_deliver.sv
module cams_deliver #(
  parameter int N  = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [N-1:0]  load_mask,
  input  logic [DW-1:0] load_data,
  input  logic [N-1:0]  rd_ready,
  output logic [N-1:0]  rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          empty
);
  logic [N-1:0]  vld_q;
  logic [DW-1:0] data_q;

  assign rd_valid = vld_q;
  assign rd_data  = data_q;
  assign empty    = (vld_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      data_q <= '0;
    end else if (load) begin
      vld_q  <= load_mask;
      data_q <= load_data;
    end else begin
      vld_q  <= vld_q & ~rd_ready;
    end
  end

  // R8: data held while any accelerator still has to take it
  p_data_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |=> $stable(rd_data));
  // R8: valid bits only clear while the buffer is occupied
  p_no_new_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |=> ((rd_valid & ~$past(rd_valid)) == '0));
endmodule

// File: rtl/cams_sched.sv
module cams_sched
  import cams_pkg::*;
#(
  parameter int N       = 4,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int MAX_OUT = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int TW = IW + 1,
  localparam int CW = $clog2(MAX_OUT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    member,
  input  logic [N*AW-1:0] base_addr,
  input  logic [N-1:0]    u_req,
  input  logic [N*AW-1:0] u_off,
  output logic [N-1:0]    u_ready,
  input  logic [N-1:0]    arrive,
  input  logic [AW-1:0]   comb_addr,
  output logic            dma_req,
  output logic [AW-1:0]   dma_addr,
  output logic [TW-1:0]   dma_tag,
  input  logic            dma_gnt,
  input  logic            dma_rvalid,
  input  logic [TW-1:0]   dma_rtag,
  input  logic [DW-1:0]   dma_rdata,
  output logic            dma_rready,
  output logic [N-1:0]    rd_valid,
  output logic [DW-1:0]   rd_data,
  input  logic [N-1:0]    rd_ready
);
  function automatic logic [AW-1:0] relocate(input logic [AW-1:0] base,
                                             input logic [AW-1:0] off);
    return base + off;
  endfunction

  phase_t        phase_q;
  logic [CW-1:0] out_cnt_q;

  logic          room, unc_ok, comb_ready, buf_empty;
  logic [N-1:0]  arb_req, arb_gnt;
  logic [IW-1:0] arb_idx;
  logic          arb_any;
  logic          unc_fire, comb_fire, rsp_fire, rsp_comb;
  logic [IW-1:0] rsp_idx;
  logic [N-1:0]  load_mask;

  assign room    = (out_cnt_q < CW'(MAX_OUT));
  assign unc_ok  = (phase_q == PH_UNC) && room;
  assign arb_req = u_req & {N{unc_ok}};

  cams_rr_pick #(.N(N)) i_arb (
    .clk(clk), .rst_n(rst_n), .req(arb_req), .advance(unc_fire),
    .gnt(arb_gnt), .idx(arb_idx), .any(arb_any)
  );

  assign comb_ready = (phase_q == PH_UNC) && (member != '0) &&
                      ((arrive & member) == member) && (u_req == '0) &&
                      (out_cnt_q == '0) && buf_empty;

  assign dma_req   = arb_any | comb_ready;
  assign dma_addr  = arb_any ? relocate(base_addr[arb_idx*AW +: AW], u_off[arb_idx*AW +: AW])
                             : comb_addr;
  assign dma_tag   = arb_any ? {1'b0, arb_idx} : {1'b1, {IW{1'b0}}};
  assign unc_fire  = arb_any & dma_gnt;
  assign comb_fire = comb_ready & dma_gnt;
  assign u_ready   = arb_gnt & {N{dma_gnt}};

  assign dma_rready = buf_empty;
  assign rsp_fire   = dma_rvalid & dma_rready;
  assign rsp_comb   = dma_rtag[TW-1];
  assign rsp_idx    = dma_rtag[IW-1:0];
  assign load_mask  = rsp_comb ? member : ({{(N-1){1'b0}}, 1'b1} << rsp_idx);

  cams_deliver #(.N(N), .DW(DW)) i_dlv (
    .clk(clk), .rst_n(rst_n), .load(rsp_fire), .load_mask(load_mask),
    .load_data(dma_rdata), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .empty(buf_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) out_cnt_q <= '0;
    else        out_cnt_q <= out_cnt_q + CW'(unc_fire) - CW'(rsp_fire && !rsp_comb);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_UNC;
    else begin
      case (phase_q)
        PH_UNC:   if (comb_fire) phase_q <= PH_WAIT;
        PH_WAIT:  if (rsp_fire && rsp_comb) phase_q <= PH_BCAST;
        PH_BCAST: if (buf_empty) phase_q <= PH_UNC;
        default:  phase_q <= PH_UNC;
      endcase
    end
  end

  p_onehot_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(u_ready));
  p_no_grant_wo_gnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_gnt |-> (u_ready == '0));
  p_private_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && !rsp_comb) |=> $onehot(rd_valid));
  p_comb_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    comb_fire |-> (out_cnt_q == '0) && ((arrive & member) == member));
  p_comb_after_unc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    comb_fire |-> (u_req == '0) && !unc_fire);
  p_bcast_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && rsp_comb) |=> (rd_valid == $past(member)));
  p_round_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_UNC) |-> !dma_req);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt_q == CW'(MAX_OUT)) |-> !unc_fire);
endmodule

// File: tb/test_cams_sched.sv
module test_cams_sched;
  localparam int N = 4, AW = 16, DW = 32, IW = 2, TW = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    member, u_req, u_ready, arrive, rd_valid, rd_ready;
  logic [N*AW-1:0] base_addr, u_off;
  logic [AW-1:0]   comb_addr, dma_addr;
  logic            dma_req, dma_gnt, dma_rvalid, dma_rready;
  logic [TW-1:0]   dma_tag, dma_rtag;
  logic [DW-1:0]   dma_rdata, rd_data;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  cams_sched #(.N(N), .AW(AW), .DW(DW), .MAX_OUT(2)) i_cams_sched (
    .clk(clk), .rst_n(rst_n), .member(member), .base_addr(base_addr),
    .u_req(u_req), .u_off(u_off), .u_ready(u_ready), .arrive(arrive),
    .comb_addr(comb_addr), .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_tag(dma_tag), .dma_gnt(dma_gnt), .dma_rvalid(dma_rvalid),
    .dma_rtag(dma_rtag), .dma_rdata(dma_rdata), .dma_rready(dma_rready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready)
  );

  // {request mask, expected granted index}
  localparam logic [7:0] VEC [0:9] = '{8'hF0, 8'hF1, 8'hA3, 8'hF0, 8'h52,
                                       8'h83, 8'h10, 8'h61, 8'h62, 8'hD3};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ret_private(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    u_req = '0; dma_rvalid = 1'b1; dma_rtag = {1'b0, IW'(idx)}; dma_rdata = d;
    #2 chk("R8 rready", 64'(dma_rready), 64'd1);
    @(negedge clk);
    dma_rvalid = 1'b0;
    #2 chk("R5 valid", 64'(rd_valid), 64'(4'b1 << idx));
    chk("R5 data", 64'(rd_data), 64'(d));
    @(negedge clk);
    #2 chk("R5 cleared", 64'(rd_valid), 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; member = '0; u_req = '0; arrive = '0; rd_ready = '1;
    dma_gnt = 1'b1; dma_rvalid = 1'b0; dma_rtag = '0; dma_rdata = '0;
    comb_addr = 16'h7F40; u_off = '0;
    for (int i = 0; i < N; i++) base_addr[i*AW +: AW] = AW'(16'h1000 * (i + 1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2 chk("R1 dma_req", 64'(dma_req), 64'd0);
    chk("R1 u_ready", 64'(u_ready), 64'd0);
    chk("R1 rd_valid", 64'(rd_valid), 64'd0);
    chk("R1 rready", 64'(dma_rready), 64'd1);

    // R2 R3 R5: table of request masks with round-robin winners
    for (int k = 0; k < 10; k++) begin
      int e;
      logic [AW-1:0] ea;
      e = int'(VEC[k][3:0]);
      @(negedge clk);
      u_req = VEC[k][7:4];
      for (int i = 0; i < N; i++) u_off[i*AW +: AW] = AW'(16'h0010 * (i + 1) + k);
      ea = AW'(16'h1000 * (e + 1) + 16'h0010 * (e + 1) + k);
      #2 chk("R3 dma_req", 64'(dma_req), 64'd1);
      chk("R3 grant", 64'(u_ready), 64'(4'b1 << e));
      chk("R2 addr", 64'(dma_addr), 64'(ea));
      chk("R2 tag", 64'(dma_tag), 64'(e));
      ret_private(e, 32'hA000_0000 + 32'(k));
    end

    // R4: no grant while channel stalls, pointer stays at 3
    @(negedge clk);
    u_req = 4'b0100; dma_gnt = 1'b0;
    #2 chk("R4 no grant", 64'(u_ready), 64'd0);
    @(negedge clk);
    u_req = 4'b1100; dma_gnt = 1'b1;
    #2 chk("R4 pointer held", 64'(u_ready), 64'b0100);
    ret_private(2, 32'h0000_0B0B);

    // R10: two outstanding, third held
    @(negedge clk);
    u_req = 4'b0001;
    #2 chk("R10 first", 64'(u_ready), 64'b0001);
    @(negedge clk);
    u_req = 4'b0010;
    #2 chk("R10 second", 64'(u_ready), 64'b0010);
    @(negedge clk);
    u_req = 4'b0100;
    #2 chk("R10 held", 64'(dma_req), 64'd0);
    dma_gnt = 1'b0; member = 4'b1011; arrive = 4'b1011;
    ret_private(0, 32'h0000_1111);
    #1 chk("R6 waits outstanding", 64'(dma_req), 64'd0);
    ret_private(1, 32'h0000_2222);
    arrive = 4'b0011;
    #1 chk("R6 lockstep", 64'(dma_req), 64'd0);
    arrive = 4'b1011;
    #1 chk("R6 comb req", 64'(dma_req), 64'd1);
    chk("R6 comb tag", 64'(dma_tag), 64'b100);
    chk("R6 comb addr", 64'(dma_addr), 64'h7F40);

    // R7: private request beats the shared read
    @(negedge clk);
    u_req = 4'b0100; dma_gnt = 1'b1;
    #2 chk("R7 private first", 64'(dma_tag), 64'b010);
    chk("R7 grant", 64'(u_ready), 64'b0100);
    ret_private(2, 32'h0000_3333);
    #1 chk("R6 comb issue", 64'(dma_tag), 64'b100);

    // R8 R9: broadcast and round boundary
    @(negedge clk);
    u_req = 4'b0001;
    #2 chk("R9 blocked wait", 64'(dma_req), 64'd0);
    dma_rvalid = 1'b1; dma_rtag = 3'b100; dma_rdata = 32'hCAFE_0001; rd_ready = 4'b0001;
    @(negedge clk);
    dma_rvalid = 1'b0; arrive = '0;
    #2 chk("R8 bcast mask", 64'(rd_valid), 64'b1011);
    chk("R8 bcast data", 64'(rd_data), 64'hCAFE_0001);
    chk("R8 rready low", 64'(dma_rready), 64'd0);
    chk("R9 blocked bcast", 64'(dma_req), 64'd0);
    @(negedge clk);
    #2 chk("R8 partial", 64'(rd_valid), 64'b1010);
    chk("R8 held data", 64'(rd_data), 64'hCAFE_0001);
    rd_ready = 4'b1010;
    @(negedge clk);
    #2 chk("R8 all taken", 64'(rd_valid), 64'd0);
    chk("R9 boundary", 64'(dma_req), 64'd0);
    rd_ready = '1;
    @(negedge clk);
    #2 chk("R9 resume", 64'(u_ready), 64'b0001);
    ret_private(0, 32'h0000_4444);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule